// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

The block takes received frames one byte per cycle from a MAC receive interface and stores them, back to back, in a circular byte region of host memory that starts at a base address. Each stored frame is a record: a 32-bit status word followed by the frame bytes, CRC included. A new record first gets an in-progress marker in its status word. The real length and status overwrite that marker only once the last byte has been written, so the host never takes a half-copied frame for a complete one.

The host consumes records through a read pointer register that holds the consumed position minus 16, modulo the ring length. It compares that position with the write pointer, or uses the empty flag, to find out whether unread records remain. A frame that would overwrite unread data is dropped and counted. Completed frames raise a one-cycle interrupt pulse: one line for good frames and another for frames that carry an error flag.

The MAC must leave the byte interface idle for at least two cycles after each last byte. The block uses those two cycles to write the final status word and the next marker.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the write pointer is 0, the read pointer register reads RING_BYTES-16, empty is 1, the missed count is 0 and both interrupts are low.
- R2: The status word at a record's start holds 0xFFF0 in bits 31:16 and zero in bits 15:0 while the frame is in progress. It is written in the cycle after reset and in the cycle after each frame ends.
- R3: Data byte k of a frame (0-based) goes to ring offset (start+4+k) mod RING_BYTES. It is written as a 32-bit write at base+(offset with bits 1:0 cleared), with byte lane offset[1:0] enabled and the byte in bits 8*lane+7:8*lane.
- R4: The final status word is written to the record start one cycle after the last byte is accepted. Bits 31:16 hold the byte count including CRC, bit 0 is receive-OK (error flag clear), bit 1 is the error flag, and all other bits are zero.
- R5: The next record starts at (start + round-up-to-4(4+length)) mod RING_BYTES. The write pointer takes that value in the same cycle as the final status write and is always a multiple of 4.
- R6: A record that runs past the ring end continues at offset 0.
- R7: A host write to the read pointer stores the written value modulo RING_BYTES, and the register reads back that value one cycle later. The consumed position is that value plus 16, modulo RING_BYTES.
- R8: empty is 1 exactly when the consumed position equals the write pointer.
- R9: A frame is accepted only if 4+length ≤ free-4, where free is (consumed − write pointer) mod RING_BYTES, or RING_BYTES when empty. A dropped frame leaves the write pointer unchanged, raises no interrupt, writes nothing past the point where it stopped fitting, and increments the missed count two cycles after its last byte.
- R10: irq_rx_ok_o pulses for one cycle when a good frame commits. irq_rx_err_o pulses for one cycle when a frame with the error flag commits; that frame is still stored, with receive-OK clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_addr_i | input | ADDR_W | Byte address of ring offset 0 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_err_i | input | 1 | Frame error flag, sampled with the last byte |
| rd_ptr_we_i | input | 1 | Host write strobe for the read pointer |
| rd_ptr_i | input | 16 | Host read pointer value (consumed position − 16) |
| rd_ptr_o | output | 16 | Read pointer readback |
| wr_ptr_o | output | 16 | Ring offset where the next record starts |
| empty_o | output | 1 | No unread records |
| missed_o | output | MISS_W | Dropped-frame count |
| irq_rx_ok_o | output | 1 | Good-frame pulse |
| irq_rx_err_o | output | 1 | Error-frame pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Word-aligned memory byte address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
Each byte shows up on the memory port one edge after it is presented. The final status word, the interrupt pulse and the new write pointer all appear together one edge after the edge that accepts the last byte. The in-progress marker for the next record follows one edge later, and a drop shows in the missed count two edges after the last byte. A read pointer write is visible on readback and on the empty flag one edge after it. The bench drives inputs on the falling edge and samples each of these results at the falling edge of exactly the cycle listed above. It checks that the interrupt is low again one cycle later, and it reads stored records back from its own memory model only after the marker write has landed.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam logic [15:0] LEN_BUSY = 16'hFFF0;
  localparam int ST_OK_BIT  = 0;
  localparam int ST_ERR_BIT = 1;

  typedef enum logic [1:0] {
    WS_ARM,
    WS_IDLE,
    WS_BODY,
    WS_FIN
  } wstate_e;
endpackage

// File: rtl/rx_ring_rdptr.sv
module rx_ring_rdptr #(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [AW-1:0] wr_pos_i,
  output logic [AW-1:0] rd_reg_o,
  output logic [AW:0]   space_o,
  output logic          empty_o
);
  logic [AW-1:0] rd_pos, diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_reg_o <= {AW{1'b1}} << 4;
    else if (we_i) rd_reg_o <= wdata_i;
  end

  always_comb begin
    rd_pos  = rd_reg_o + AW'(16);
    diff    = rd_pos - wr_pos_i;
    empty_o = (diff == '0);
    space_o = empty_o ? {1'b1, {AW{1'b0}}} : {1'b0, diff};
  end

  // R7
  rdreg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rd_reg_o == $past(wdata_i));
endmodule

// File: rtl/rx_ring_miss.sv
module rx_ring_miss #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  // R9
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == $past(cnt_o) + W'(1));
endmodule

// File: rtl/rx_ring_wr.sv
module rx_ring_wr
  import rx_ring_pkg::*;
#(
  parameter int AW     = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  input  logic [AW:0]       space_i,
  output logic [AW-1:0]     wr_pos_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              irq_ok_o,
  output logic              irq_err_o,
  output logic              drop_o
);
  localparam int LW = AW + 1;

  wstate_e       state;
  logic [LW-1:0] len_q, len_n;
  logic          err_q, drop_q;
  logic [AW-1:0] cursor, rec, step, next_pos;
  logic [AW+1:0] need, room;
  logic          fits;
  logic [15:0]   hdr_lo;

  always_comb begin
    len_n    = len_q + LW'(1);
    cursor   = wr_pos_o + AW'(4) + len_q[AW-1:0];
    need     = {1'b0, len_n} + (AW+2)'(8);
    room     = {1'b0, space_i};
    fits     = (need <= room);
    rec      = len_q[AW-1:0] + AW'(7);
    step     = {rec[AW-1:2], 2'b00};
    next_pos = wr_pos_o + step;
    hdr_lo   = '0;
    hdr_lo[ST_OK_BIT]  = ~err_q;
    hdr_lo[ST_ERR_BIT] = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= WS_ARM;
      wr_pos_o    <= '0;
      len_q       <= '0;
      err_q       <= 1'b0;
      drop_q      <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      irq_ok_o    <= 1'b0;
      irq_err_o   <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      mem_we_o  <= 1'b0;
      irq_ok_o  <= 1'b0;
      irq_err_o <= 1'b0;
      drop_o    <= 1'b0;
      case (state)
        WS_ARM: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= base_addr_i + ADDR_W'(wr_pos_o);
          mem_be_o    <= 4'hF;
          mem_wdata_o <= {LEN_BUSY, 16'h0000};
          len_q       <= '0;
          err_q       <= 1'b0;
          drop_q      <= 1'b0;
          state       <= WS_IDLE;
        end
        WS_IDLE, WS_BODY: begin
          if (rx_valid_i) begin
            len_q <= len_n;
            if (!drop_q && fits) begin
              mem_we_o    <= 1'b1;
              mem_addr_o  <= base_addr_i + ADDR_W'({cursor[AW-1:2], 2'b00});
              mem_be_o    <= 4'b0001 << cursor[1:0];
              mem_wdata_o <= {4{rx_data_i}};
            end else begin
              drop_q <= 1'b1;
            end
            if (rx_last_i) begin
              err_q <= rx_err_i;
              state <= WS_FIN;
            end else begin
              state <= WS_BODY;
            end
          end
        end
        WS_FIN: begin
          if (drop_q) begin
            drop_o <= 1'b1;
          end else begin
            mem_we_o    <= 1'b1;
            mem_addr_o  <= base_addr_i + ADDR_W'(wr_pos_o);
            mem_be_o    <= 4'hF;
            mem_wdata_o <= {16'(len_q), hdr_lo};
            wr_pos_o    <= next_pos;
            irq_ok_o    <= ~err_q;
            irq_err_o   <= err_q;
          end
          state <= WS_ARM;
        end
        default: state <= WS_ARM;
      endcase
    end
  end

  // R5
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pos_o[1:0] == 2'b00);
  // R10
  irq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_ok_o && irq_err_o));
  // R4
  hdr_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ok_o || irq_err_o) |-> mem_we_o && mem_be_o == 4'hF && mem_wdata_o[31:16] != LEN_BUSY);
  // R2
  busy_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ok_o || irq_err_o || drop_o) |=> mem_we_o && mem_wdata_o == {LEN_BUSY, 16'h0000});
  // R2
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WS_FIN || state == WS_ARM) |-> !rx_valid_i);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int RING_BYTES = 8192,
  parameter int ADDR_W     = 32,
  parameter int MISS_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  input  logic              rd_ptr_we_i,
  input  logic [15:0]       rd_ptr_i,
  output logic [15:0]       rd_ptr_o,
  output logic [15:0]       wr_ptr_o,
  output logic              empty_o,
  output logic [MISS_W-1:0] missed_o,
  output logic              irq_rx_ok_o,
  output logic              irq_rx_err_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o
);
  localparam int AW = $clog2(RING_BYTES);

  logic [AW-1:0] wr_pos, rd_reg;
  logic [AW:0]   space;
  logic          drop;

  generate
    if (AW < 16) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^rd_ptr_i[15:AW];
    end
  endgenerate

  rx_ring_rdptr #(.AW(AW)) u_rdptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rd_ptr_we_i),
    .wdata_i  (rd_ptr_i[AW-1:0]),
    .wr_pos_i (wr_pos),
    .rd_reg_o (rd_reg),
    .space_o  (space),
    .empty_o  (empty_o)
  );

  rx_ring_wr #(.AW(AW), .ADDR_W(ADDR_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_addr_i (base_addr_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_last_i   (rx_last_i),
    .rx_err_i    (rx_err_i),
    .space_i     (space),
    .wr_pos_o    (wr_pos),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .irq_ok_o    (irq_rx_ok_o),
    .irq_err_o   (irq_rx_err_o),
    .drop_o      (drop)
  );

  rx_ring_miss #(.W(MISS_W)) u_miss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (missed_o)
  );

  assign rd_ptr_o = 16'(rd_reg);
  assign wr_ptr_o = 16'(wr_pos);

  // R9
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_o != $past(missed_o)) |-> (wr_ptr_o == $past(wr_ptr_o)) && !irq_rx_ok_o && !irq_rx_err_o);
  // R5
  ptr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_o != $past(wr_ptr_o)) |-> (irq_rx_ok_o || irq_rx_err_o));
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 8192;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rd_we = 1'b0;
  logic [15:0] rd_wdata = '0;
  logic [15:0] rd_ptr, wr_ptr;
  logic empty, irq_ok, irq_err, mem_we;
  logic [15:0] missed;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;

  int n_chk = 0, n_fail = 0, bad_addr = 0;
  int exp_wr = 0, exp_miss = 0;
  logic [31:0] mem_model [RING/4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer #(.RING_BYTES(RING)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_addr_i(BASE),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_err_i(rx_err),
    .rd_ptr_we_i(rd_we), .rd_ptr_i(rd_wdata), .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr),
    .empty_o(empty), .missed_o(missed), .irq_rx_ok_o(irq_ok), .irq_rx_err_o(irq_err),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin : mdl
    logic [31:0] a;
    if (mem_we) begin
      a = mem_addr - BASE;
      if (a >= RING || a[1:0] != 2'b00) bad_addr++;
      else
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem_model[a >> 2][8*l +: 8] <= mem_wdata[8*l +: 8];
    end
  end

  function automatic logic [7:0] mbyte(int off);
    int o = off % RING;
    return mem_model[o >> 2][8*(o%4) +: 8];
  endfunction

  function automatic logic [31:0] mword(int off);
    return mem_model[(off % RING) >> 2];
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_rd(int val);
    @(negedge clk);
    rd_we = 1'b1; rd_wdata = 16'(val);
    @(negedge clk);
    rd_we = 1'b0;
  endtask

  task automatic check_frame(string tag, int start, int len, int seed, bit err);
    int bad = 0;
    chk({tag, " header"}, mword(start), {16'(len), 14'b0, err, ~err});
    for (int i = 0; i < len; i++)
      if (mbyte(start + 4 + i) != pat(seed, i)) bad++;
    chk({tag, " data bytes"}, bad, 0);
  endtask

  // Send one frame and check the commit cycle, the pulse width and the missed count.
  task automatic send_frame(string tag, int len, int seed, bit err, bit drop, bit mid);
    int start = exp_wr;
    int nxt = (start + ((4 + len + 3) / 4) * 4) % RING;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, i);
      rx_last = (i == len - 1); rx_err = (i == len - 1) ? err : 1'b0;
      if (mid && i == len / 2)
        chk({tag, " R2 in-progress marker"}, mword(start), 32'hFFF0_0000);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    @(negedge clk);
    chk({tag, " R10 irq_ok"}, irq_ok, (!drop && !err));
    chk({tag, " R10 irq_err"}, irq_err, (!drop && err));
    chk({tag, " R5 wr_ptr"}, wr_ptr, drop ? start : nxt);
    @(negedge clk);
    chk({tag, " R10 pulse ends"}, irq_ok | irq_err, 0);
    if (drop) exp_miss++;
    chk({tag, " R9 missed"}, missed, exp_miss);
    if (!drop) exp_wr = nxt;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 rd_ptr", rd_ptr, RING - 16);
    chk("R1 empty", empty, 1);
    chk("R1 missed", missed, 0);
    chk("R1 irqs", irq_ok | irq_err, 0);
    repeat (3) @(negedge clk);
    chk("R2 marker after reset", mword(0), 32'hFFF0_0000);
  endtask

  task automatic t_basic;
    send_frame("basic", 64, 1, 1'b0, 1'b0, 1'b1);
    check_frame("R3 R4 basic", 0, 64, 1, 1'b0);
    chk("R5 basic next", exp_wr, 68);
    chk("R8 not empty", empty, 0);
    chk("R2 marker next", mword(exp_wr), 32'hFFF0_0000);
  endtask

  task automatic t_odd_err;
    send_frame("odd", 61, 2, 1'b0, 1'b0, 1'b1);
    check_frame("R4 odd", 68, 61, 2, 1'b0);
    chk("R5 odd rounding", exp_wr, 136);
    send_frame("err", 70, 3, 1'b1, 1'b0, 1'b0);
    check_frame("R4 R10 err stored", 136, 70, 3, 1'b1);
    chk("R5 err next", exp_wr, 212);
  endtask

  task automatic t_consume;
    set_rd(16'hE0C4);
    chk("R7 rd_ptr modulo ring", rd_ptr, 196);
    chk("R8 empty after consume", empty, 1);
    set_rd(52);
    chk("R7 rd_ptr readback", rd_ptr, 52);
    chk("R8 unread remains", empty, 0);
    set_rd(196);
    chk("R8 empty again", empty, 1);
  endtask

  task automatic t_wrap;
    int s;
    while (exp_wr + 1600 < RING) begin
      send_frame("fill", 1500, 9, 1'b0, 1'b0, 1'b0);
      set_rd((exp_wr - 16 + RING) % RING);
    end
    s = exp_wr;
    send_frame("wrap", 1000, 5, 1'b0, 1'b0, 1'b1);
    check_frame("R6 wrap", s, 1000, 5, 1'b0);
    chk("R6 wrap next", exp_wr, (s + 1004) % RING);
    set_rd((exp_wr - 16 + RING) % RING);
    chk("R8 empty after wrap", empty, 1);
  endtask

  task automatic t_overflow;
    int w = exp_wr;
    logic [31:0] guard;
    set_rd((w + 128 - 16) % RING);
    chk("R8 space limited", empty, 0);
    guard = mword(w + 128);
    send_frame("R9 drop 121", 121, 6, 1'b0, 1'b1, 1'b0);
    chk("R9 marker kept", mword(w), 32'hFFF0_0000);
    send_frame("R9 fit 120", 120, 7, 1'b0, 1'b0, 1'b0);
    check_frame("R9 fit", w, 120, 7, 1'b0);
    send_frame("R9 drop 1", 1, 8, 1'b0, 1'b1, 1'b0);
    chk("R9 unread intact", mword(w + 128), guard);
    chk("R9 wr_ptr held", wr_ptr, (w + 124) % RING);
  endtask

  initial begin
    for (int i = 0; i < RING / 4; i++) mem_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_odd_err();
    t_consume();
    t_wrap();
    t_overflow();
    chk("R3 address range", bad_addr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule